// File: doc/BRIEF.md
# Statistical Operation Sampling Selector

This block chooses single operations for detailed profiling out of a stream of eligible operations. A down-counter is loaded with a programmable interval. Every eligible operation decrements it. The operation that arrives when the count runs out is chosen. The block can randomise each reloaded interval with a small pseudo-random offset, so that the sampling does not lock onto the period of a program loop.

Only one chosen operation may be in flight at a time. A chosen operation sets a busy flag, and the busy flag stays set until the completion strobe for that operation arrives. If the count runs out while an earlier operation is still busy, the new choice is dropped and a collision event is raised. This happens before any downstream record filtering. The block also raises a pulse for every eligible operation and for every accepted selection, so that a performance counter can count the population, the samples and the losses.

Top module: `op_sample_sel`

## Requirements
- R1: A synchronous reset clears busy and the three event outputs to 0, zeroes the down-counter and sets the jitter generator to 16'hACE1. If the block is enabled straight out of reset, the first eligible operation is therefore chosen.
- R2: With jitter off and an interval N ≥ 1 loaded, the N-th eligible operation (`en` and `op_vld` both 1) is chosen, and after that every N-th one. `sample_sel` is combinational and is high in the same cycle as the chosen operation.
- R3: While `en` is 0, no operation is counted or chosen and no event is raised. In every such cycle the counter is re-armed with the current reload value.
- R4: `ev_pop` pulses for one cycle, one cycle after each eligible operation.
- R5: `busy` rises in the cycle after an accepted selection and falls in the cycle after `op_done`. While `busy` is 1 and `op_done` is 0, no selection is accepted.
- R6: If the count runs out while `busy` is 1 and `op_done` is 0, `sample_sel` stays 0, `busy` is unchanged and `ev_collide` pulses one cycle later.
- R7: If `op_done` arrives in the same cycle as an expiry, the new selection is accepted.
- R8: After a collision the counter reloads exactly as it does after an accepted selection, so the next expiry comes a full interval later.
- R9: When `jitter_en` is 1, the reload value is `interval` with its low 8 bits XORed with bits 7:0 of a 16-bit LFSR. The LFSR shifts left and feeds bit0 with the XOR of bits 15, 13, 12 and 10. It steps once after every expiry that happens with jitter on. A reload uses the LFSR value from before the step.
- R10: The reload value is never below 1. A computed value of 0 becomes 1, so every eligible operation expires.
- R11: `ev_sampled` pulses one cycle after each accepted selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Global sampling enable |
| op_vld | input | 1 | An operation eligible for sampling is present |
| op_done | input | 1 | The sampled operation in flight completes |
| interval | input | CNT_W | Sampling interval in operations |
| jitter_en | input | 1 | Randomise each reloaded interval |
| sample_sel | output | 1 | The current operation is chosen as a sample |
| busy | output | 1 | A sampled operation is in flight |
| ev_pop | output | 1 | Population event, one cycle after an eligible operation |
| ev_sampled | output | 1 | Sample event, one cycle after an accepted selection |
| ev_collide | output | 1 | Collision event, one cycle after a dropped selection |

## Verification
A wrong count or reload value moves the first mismatching `sample_sel` by one or more operations. The error shows on the next expiry, within one interval of eligible operations. A wrong LFSR step changes every jittered interval that follows, so the first jittered reload after the error already differs. A busy flag that is set or cleared wrongly shows up at the next expiry that overlaps a sample in flight: `sample_sel` and `ev_collide` swap at that point. Event pulses are checked every cycle, so a timing slip in an event output is seen in the cycle where it happens.

// File: rtl/osel_pkg.sv
package osel_pkg;

   localparam int unsigned OSEL_LFSR_W = 16;
   localparam logic [OSEL_LFSR_W-1:0] OSEL_SEED = 16'hACE1;

   // x^16 + x^14 + x^13 + x^11 + 1, shift towards the MSB
   function automatic logic [OSEL_LFSR_W-1:0] osel_lfsr_next(input logic [OSEL_LFSR_W-1:0] s);
      logic fb;
      fb = s[15] ^ s[13] ^ s[12] ^ s[10];
      return {s[OSEL_LFSR_W-2:0], fb};
   endfunction

endpackage

// File: rtl/osel_lfsr.sv
module osel_lfsr
   import osel_pkg::*;
#(
   parameter bit                    IMPL = 1'b1,
   parameter logic [OSEL_LFSR_W-1:0] SEED = OSEL_SEED
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   step,
   output logic [OSEL_LFSR_W-1:0] state
);

   if (SEED == '0) begin : g_bad_seed
      $error("osel_lfsr: seed must be nonzero");
   end

   if (IMPL) begin : g_lfsr
      logic [OSEL_LFSR_W-1:0] s_q;

      always_ff @(posedge clk) begin
         if (rst)       s_q <= SEED;
         else if (step) s_q <= osel_lfsr_next(s_q);
      end

      assign state = s_q;

      AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
         s_q != '0);                                               // R9
      AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (rst)
         !step |=> $stable(s_q));                                   // R9
   end else begin : g_no_lfsr
      logic unused_step;
      assign unused_step = step;
      assign state       = '0;
   end

endmodule

// File: rtl/osel_reload.sv
module osel_reload #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned JIT_W = 8
) (
   input  logic [CNT_W-1:0] interval,
   input  logic             jitter_on,
   input  logic [JIT_W-1:0] noise,
   output logic [CNT_W-1:0] reload
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [JIT_W-1:0] noise_g;
   logic [CNT_W-1:0] mixed;

   assign noise_g = jitter_on ? noise : '0;

   if (JIT_W == CNT_W) begin : g_full
      assign mixed = interval ^ noise_g;
   end else begin : g_low
      assign mixed = {interval[CNT_W-1:JIT_W], interval[JIT_W-1:0] ^ noise_g};
   end

   always_comb begin
      reload = mixed;
      if (mixed == '0) reload = ONE;
   end

   always_comb begin
      AST_RELOAD_MIN: assert (reload != '0);                        // R10
   end

endmodule

// File: rtl/osel_countdown.sv
module osel_countdown #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             op_vld,
   input  logic [CNT_W-1:0] reload,
   output logic             expire
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             elig;
   logic             run_out;

   assign elig    = en & op_vld;
   assign run_out = (cnt_q <= ONE);
   assign expire  = elig & run_out;

   always_ff @(posedge clk) begin
      if (rst)          cnt_q <= '0;
      else if (!en)     cnt_q <= reload;
      else if (op_vld)  cnt_q <= run_out ? reload : cnt_q - ONE;
   end

   AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
      (!en || op_vld) |=> cnt_q != '0);                             // R10
   AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (rst)
      (en && !op_vld) |=> $stable(cnt_q));                          // R2

endmodule

// File: rtl/osel_track.sv
module osel_track (
   input  logic clk,
   input  logic rst,
   input  logic hit,
   input  logic op_done,
   output logic accept,
   output logic collide,
   output logic busy
);

   logic busy_q;
   logic free;

   assign free    = ~busy_q | op_done;
   assign accept  = hit & free;
   assign collide = hit & ~free;
   assign busy    = busy_q;

   always_ff @(posedge clk) begin
      if (rst)          busy_q <= 1'b0;
      else if (accept)  busy_q <= 1'b1;
      else if (op_done) busy_q <= 1'b0;
   end

   AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (rst)
      (busy_q && !op_done) |-> !accept);                            // R5
   AST_BUSY_SET: assert property (@(posedge clk) disable iff (rst)
      accept |=> busy_q);                                           // R5
   AST_COLLIDE_KEEPS: assert property (@(posedge clk) disable iff (rst)
      collide |=> busy_q);                                          // R6
   AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      !(accept && collide));                                        // R6

endmodule

// File: rtl/op_sample_sel.sv
module op_sample_sel
   import osel_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned JIT_W       = 8,
   parameter bit          JITTER_IMPL = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             op_vld,
   input  logic             op_done,
   input  logic [CNT_W-1:0] interval,
   input  logic             jitter_en,
   output logic             sample_sel,
   output logic             busy,
   output logic             ev_pop,
   output logic             ev_sampled,
   output logic             ev_collide
);

   if (CNT_W < 2) begin : g_chk_cnt
      $error("op_sample_sel: CNT_W must be at least 2");
   end
   if (JIT_W < 1 || JIT_W > CNT_W || JIT_W > OSEL_LFSR_W) begin : g_chk_jit
      $error("op_sample_sel: JIT_W must lie in 1..min(CNT_W,16)");
   end

   logic [OSEL_LFSR_W-1:0] lfsr_s;
   logic [CNT_W-1:0]       reload;
   logic                   jit_on;
   logic                   expire;
   logic                   accept;
   logic                   collide;
   logic                   elig;

   assign jit_on = JITTER_IMPL & jitter_en;
   assign elig   = en & op_vld;

   osel_lfsr #(.IMPL(JITTER_IMPL), .SEED(OSEL_SEED)) u_lfsr (
      .clk   (clk),
      .rst   (rst),
      .step  (expire & jit_on),
      .state (lfsr_s)
   );

   osel_reload #(.CNT_W(CNT_W), .JIT_W(JIT_W)) u_reload (
      .interval  (interval),
      .jitter_on (jit_on),
      .noise     (lfsr_s[JIT_W-1:0]),
      .reload    (reload)
   );

   osel_countdown #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .en     (en),
      .op_vld (op_vld),
      .reload (reload),
      .expire (expire)
   );

   osel_track u_track (
      .clk     (clk),
      .rst     (rst),
      .hit     (expire),
      .op_done (op_done),
      .accept  (accept),
      .collide (collide),
      .busy    (busy)
   );

   assign sample_sel = accept;

   always_ff @(posedge clk) begin
      if (rst) begin
         ev_pop     <= 1'b0;
         ev_sampled <= 1'b0;
         ev_collide <= 1'b0;
      end else begin
         ev_pop     <= elig;
         ev_sampled <= accept;
         ev_collide <= collide;
      end
   end

   AST_QUIET_OFF: assert property (@(posedge clk) disable iff (rst)
      !en |-> !sample_sel);                                         // R3
   AST_POP_AFTER_SEL: assert property (@(posedge clk) disable iff (rst)
      sample_sel |=> ev_pop);                                       // R4
   AST_SAMPLED_AFTER_SEL: assert property (@(posedge clk) disable iff (rst)
      sample_sel |=> ev_sampled);                                   // R11
   AST_COLLIDE_NO_SEL: assert property (@(posedge clk) disable iff (rst)
      ev_collide |-> (busy && !ev_sampled));                        // R6
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
      (busy && !op_done) |=> busy);                                 // R5

endmodule

// File: tb/tb_op_sample_sel.sv
module tb_op_sample_sel;

   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             en = 1'b0;
   logic             op_vld = 1'b0;
   logic             op_done = 1'b0;
   logic [CNT_W-1:0] interval = '0;
   logic             jitter_en = 1'b0;
   logic             sample_sel, busy, ev_pop, ev_sampled, ev_collide;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   // bench-side expectation state
   int          m_cnt;
   bit          m_busy, m_pop, m_samp, m_col;
   logic [15:0] m_lfsr;
   int          m_lat;

   always #2 clk = ~clk;

   op_sample_sel #(.CNT_W(CNT_W), .JIT_W(8), .JITTER_IMPL(1'b1)) dut (
      .clk(clk), .rst(rst), .en(en), .op_vld(op_vld), .op_done(op_done),
      .interval(interval), .jitter_en(jitter_en),
      .sample_sel(sample_sel), .busy(busy), .ev_pop(ev_pop),
      .ev_sampled(ev_sampled), .ev_collide(ev_collide)
   );

   task automatic chk(input string what, input logic act, input logic exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic int reload_val();
      int r;
      r = int'(interval);
      if (jitter_en) r = r ^ int'(m_lfsr[7:0]);
      if (r == 0) r = 1;
      return r;
   endfunction

   function automatic logic [15:0] lfsr_adv(input logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   task automatic model_init();
      m_cnt = 0; m_busy = 0; m_pop = 0; m_samp = 0; m_col = 0;
      m_lfsr = 16'hACE1; m_lat = 0;
   endtask

   // one cycle: drive at the falling edge, check 1 ns later, advance model
   task automatic step(input logic e, input logic v, input logic d, input string tag);
      bit elig, ex, acc, col;
      en = e; op_vld = v; op_done = d;
      #1;
      elig = e && v;
      ex   = elig && (m_cnt <= 1);
      acc  = ex && (!m_busy || d);
      col  = ex && m_busy && !d;
      chk("sample_sel", sample_sel, acc, tag);
      chk("busy", busy, m_busy, "R5");
      chk("ev_pop", ev_pop, m_pop, "R4");
      chk("ev_sampled", ev_sampled, m_samp, "R11");
      chk("ev_collide", ev_collide, m_col, "R6");
      if (!e) m_cnt = reload_val();
      else if (v) begin
         if (ex) begin
            m_cnt = reload_val();
            if (jitter_en) m_lfsr = lfsr_adv(m_lfsr);
         end else m_cnt = m_cnt - 1;
      end
      if (acc) m_busy = 1; else if (d) m_busy = 0;
      m_pop = elig; m_samp = acc; m_col = col;
      @(negedge clk);
   endtask

   // run with op pattern every 'per' cycles and completion after 'lat' busy cycles
   task automatic run(input int cycles, input int per, input int lat, input string tag);
      for (int c = 0; c < cycles; c++) begin
         logic d;
         d = m_busy && (m_lat >= lat);
         if (m_busy && !d) m_lat++; else m_lat = 0;
         step(1'b1, (c % per) == 0, d, tag);
      end
   endtask

   task automatic flush();
      for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 1'b1, "R3");
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      if (!finished) begin
         $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
         $finish;
      end
   end

   initial begin
      model_init();
      @(negedge clk); @(negedge clk);
      #1;
      chk("busy", busy, 1'b0, "R1");
      chk("ev_pop", ev_pop, 1'b0, "R1");
      chk("ev_sampled", ev_sampled, 1'b0, "R1");
      chk("ev_collide", ev_collide, 1'b0, "R1");
      @(negedge clk);
      rst = 1'b0;
      interval = 16'd5;
      // R1: counter is zero after reset, so the first op is taken
      step(1'b1, 1'b1, 1'b0, "R1");
      step(1'b1, 1'b1, 1'b1, "R1");
      flush();

      // R2 and R3 sweep: intervals 1..6, op density, completion latency
      for (int iv = 1; iv <= 6; iv++)
         for (int per = 1; per <= 3; per++)
            for (int lat = 0; lat <= 3; lat++) begin
               interval = 16'(iv);
               step(1'b0, 1'b1, 1'b0, "R3");   // ops ignored, counter re-armed
               run(30, per, lat, "R2");
               flush();
            end

      // R10: interval 0 behaves as 1
      interval = 16'd0;
      step(1'b0, 1'b1, 1'b0, "R3");
      run(20, 1, 0, "R10");
      run(20, 2, 2, "R10");
      flush();

      // R7: completion on the expiry cycle lets every op through
      interval = 16'd1;
      step(1'b0, 1'b0, 1'b0, "R3");
      for (int k = 0; k < 20; k++) step(1'b1, 1'b1, 1'b1, "R7");
      flush();

      // R8 and R6: long completion forces collisions, next expiry a full interval later
      interval = 16'd3;
      step(1'b0, 1'b0, 1'b0, "R3");
      run(60, 1, 7, "R8");
      flush();

      // R9: jittered reloads, including a low byte that can XOR to zero
      jitter_en = 1'b1;
      foreach (interval[i]) ;
      interval = 16'h0003;
      step(1'b0, 1'b0, 1'b0, "R3");
      run(2500, 1, 1, "R9");
      flush();
      interval = 16'h0100;
      step(1'b0, 1'b0, 1'b0, "R3");
      run(2500, 1, 0, "R9");
      flush();
      interval = 16'h00E1;
      step(1'b0, 1'b0, 1'b0, "R3");
      run(2000, 1, 3, "R9");
      flush();
      jitter_en = 1'b0;

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule